// File: doc/BRIEF.md
# Recirculating Text Screen Refresh Engine

This block keeps a 40-column by 24-row text screen in a circulating store that software cannot address. Each stored cell holds a 6-bit character code and a one-bit cursor mark, and the store has 1024 positions. The store is read only as it turns: it advances one position per character slot on the first scan line of each text row, which gives 960 steps, and it makes the remaining 64 steps during vertical blanking. Every frame therefore brings each position back to the same screen cell.

A character row takes eight scan lines, but the store can yield a row only once per frame. For that reason the engine copies each row into a 40-cell circulating line buffer on the row's first scan line, and it replays that buffer unchanged on the other seven. On every visible slot it presents the character code, the cursor mark and the scan-line index to a downstream glyph lookup, and it pulses a valid strobe. A glyph lookup produces 5x7 dot patterns.

A keyboard-side writer pulses a strobe with a new code. The engine holds that code until the circulating cursor mark arrives. At that point it stores the code in place of the old one and moves the mark on by one position.

Top module: `char_ring_display`

## Requirements
- R1: While reset is asserted and in the first cycle after it, buf_valid, code_out, line_out and cursor_out are all 0.
- R2: During the first 1024 ring steps after reset, every position is rewritten with code 0. The cursor mark is set only at position 0 (row 0, column 0). No pending write is committed during this pass.
- R3: If char_tick is high in a cycle with h_pos < 40 and v_line < 192, buf_valid is 1 in the next cycle and carries that slot's cell. In every other case buf_valid is 0 in the next cycle, which gives exactly 7680 pulses per frame.
- R4: Suppose a code is pending and the ring steps past the position that holds the cursor mark. The pending code replaces the stored code at that position, the shown cell carries the new code with cursor 0, and the mark is set at the next position.
- R5: A wr_stb that arrives while a code is already pending is ignored, so the earlier code is the one stored.
- R6: On scan lines where v_line mod 8 is not 0, a row's 40 cells are the same as those shown on that row's scan line 0. line_out equals v_line mod 8.
- R7: The ring advances one position per char_tick in two cases only: on visible slots of scan lines with v_line mod 8 = 0, and on slots with h_pos < 64 when v_line = 192. Position index is row*40+column, and contents persist from frame to frame.
- R8: A pending code stays pending across scan lines, blanking and frames until the cursor position is stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_tick | input | 1 | Character-slot enable |
| h_pos | input | 7 | Character slot within the scan line |
| v_line | input | 8 | Scan line within the frame |
| wr_stb | input | 1 | New-character write strobe |
| wr_code | input | 6 | Code to write at the cursor |
| code_out | output | 6 | Character code for the glyph lookup |
| line_out | output | 3 | Scan line within the text row |
| cursor_out | output | 1 | Cursor mark for this cell |
| buf_valid | output | 1 | One-cycle strobe that qualifies the outputs |

## Verification
The bench uses a bit-level model of the ring, the pending write and the line buffer to predict every slot across whole frames, some of them with idle cycles between slots. The corner cases it targets are these:
- A write issued after the cursor's row has already been loaded. A design that commits too early would show the code one frame too soon.
- A second strobe while a code is pending. A design that let it through would store the later code.
- The 64 blanking steps. If these were wrong, a commit would land in the wrong column in the next frame.
- The replayed scan lines. A line buffer that rotated wrongly would show column-shifted text on lines 1 to 7.

// File: rtl/char_ring_pkg.sv
package char_ring_pkg;

  // Slot lies inside the visible text area.
  function automatic logic in_text_area(int h, int v, int cols, int text_lines);
    return (h < cols) && (v < text_lines);
  endfunction

  // Number of ring steps left over once every visible cell has passed.
  function automatic int spare_steps(int ring_len, int cols, int rows);
    return ring_len - cols * rows;
  endfunction

  // Slot belongs to the blanking run that completes the ring turn.
  function automatic logic in_blank_run(int h, int v, int text_lines, int spare);
    return (v == text_lines) && (h < spare);
  endfunction

endpackage

// File: rtl/screen_ring.sv
module screen_ring #(
  parameter int RING_LEN = 1024,
  parameter int CODE_W   = 6,
  localparam int PTR_W   = $clog2(RING_LEN),
  localparam int CELL_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CELL_W-1:0] head_cell,
  output logic              wr_commit,
  output logic              wr_pend,
  output logic              clr_busy
);
  logic [CELL_W-1:0] store [RING_LEN];
  logic [PTR_W-1:0]  ptr;
  logic              carry;
  logic              cleared;
  logic [CODE_W-1:0] pend_code;
  logic [CELL_W-1:0] base;
  logic              cur_here;
  logic              take;

  always_comb begin
    base      = cleared ? store[ptr] : {(ptr == '0), {CODE_W{1'b0}}};
    cur_here  = base[CODE_W] | carry;
    take      = cleared && wr_pend && cur_here;
    head_cell = take ? {1'b0, pend_code} : {cur_here, base[CODE_W-1:0]};
    wr_commit = shift && take;
    clr_busy  = !cleared;
  end

  always_ff @(posedge clk) begin
    if (shift) store[ptr] <= head_cell;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      carry     <= 1'b0;
      cleared   <= 1'b0;
      wr_pend   <= 1'b0;
      pend_code <= '0;
    end else begin
      if (shift) begin
        carry <= wr_commit;
        if (ptr == PTR_W'(RING_LEN - 1)) begin
          ptr     <= '0;
          cleared <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (wr_commit) begin
        wr_pend <= 1'b0;
      end else if (wr_stb && !wr_pend) begin
        wr_pend   <= 1'b1;
        pend_code <= wr_code;
      end
    end
  end
endmodule

// File: rtl/line_buf.sv
module line_buf #(
  parameter int DEPTH = 40,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] head_out
);
  logic [W-1:0] sr [DEPTH];

  assign head_out = load ? din : sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (step) begin
      for (int i = 0; i < DEPTH - 1; i++) sr[i] <= sr[i+1];
      sr[DEPTH-1] <= head_out;
    end
  end
endmodule

// File: rtl/char_ring_display.sv
module char_ring_display
  import char_ring_pkg::*;
#(
  parameter int COLS     = 40,
  parameter int ROWS     = 24,
  parameter int LINES    = 8,
  parameter int CODE_W   = 6,
  parameter int RING_LEN = 1024,
  parameter int H_W      = 7,
  parameter int V_W      = 8,
  localparam int LINE_W     = $clog2(LINES),
  localparam int TEXT_LINES = ROWS * LINES,
  localparam int SPARE      = spare_steps(RING_LEN, COLS, ROWS),
  localparam int CELL_W     = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_tick,
  input  logic [H_W-1:0]    h_pos,
  input  logic [V_W-1:0]    v_line,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code_out,
  output logic [LINE_W-1:0] line_out,
  output logic              cursor_out,
  output logic              buf_valid
);
  logic              slot_vis;
  logic              first_line;
  logic              ring_shift;
  logic [CELL_W-1:0] ring_cell;
  logic [CELL_W-1:0] shown;
  logic              wr_commit;
  logic              wr_pend;
  logic              clr_busy;

  always_comb begin
    slot_vis   = char_tick && in_text_area(int'(h_pos), int'(v_line), COLS, TEXT_LINES);
    first_line = (v_line[LINE_W-1:0] == '0);
    ring_shift = (slot_vis && first_line) ||
                 (char_tick && in_blank_run(int'(h_pos), int'(v_line), TEXT_LINES, SPARE));
  end

  screen_ring #(.RING_LEN(RING_LEN), .CODE_W(CODE_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .shift(ring_shift), .wr_stb(wr_stb), .wr_code(wr_code),
    .head_cell(ring_cell), .wr_commit(wr_commit), .wr_pend(wr_pend), .clr_busy(clr_busy)
  );

  line_buf #(.DEPTH(COLS), .W(CELL_W)) u_lbuf (
    .clk(clk), .rst_n(rst_n), .step(slot_vis), .load(first_line),
    .din(ring_cell), .head_out(shown)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_out   <= '0;
      line_out   <= '0;
      cursor_out <= 1'b0;
      buf_valid  <= 1'b0;
    end else begin
      buf_valid <= slot_vis;
      if (slot_vis) begin
        code_out   <= shown[CODE_W-1:0];
        cursor_out <= shown[CODE_W];
        line_out   <= v_line[LINE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/char_ring_display_chk.sv
module char_ring_display_chk #(
  parameter int COLS   = 40,
  parameter int ROWS   = 24,
  parameter int LINES  = 8,
  parameter int CODE_W = 6,
  parameter int H_W    = 7,
  parameter int V_W    = 8,
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_tick,
  input logic [H_W-1:0]    h_pos,
  input logic [V_W-1:0]    v_line,
  input logic [CODE_W-1:0] code_out,
  input logic [LINE_W-1:0] line_out,
  input logic              buf_valid,
  input logic              wr_commit,
  input logic              wr_pend,
  input logic              clr_busy
);
  assert_valid_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> ($past(char_tick) && int'($past(h_pos)) < COLS &&
                   int'($past(v_line)) < ROWS * LINES));

  assert_scan_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (line_out == $past(v_line[LINE_W-1:0])));

  assert_clear_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && $past(clr_busy)) |-> (code_out == '0));

  assert_commit_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_pend);

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !wr_commit) |=> wr_pend);
endmodule

bind char_ring_display char_ring_display_chk #(
  .COLS(COLS), .ROWS(ROWS), .LINES(LINES), .CODE_W(CODE_W), .H_W(H_W), .V_W(V_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .h_pos(h_pos), .v_line(v_line),
  .code_out(code_out), .line_out(line_out), .buf_valid(buf_valid),
  .wr_commit(wr_commit), .wr_pend(wr_pend), .clr_busy(clr_busy)
);

// File: tb/tb_char_ring_display.sv
module tb_char_ring_display;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_tick = 1'b0;
  logic [6:0] h_pos = '0;
  logic [7:0] v_line = '0;
  logic       wr_stb = 1'b0;
  logic [5:0] wr_code = '0;
  logic [5:0] code_out;
  logic [2:0] line_out;
  logic       cursor_out;
  logic       buf_valid;

  char_ring_display dut (
    .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .h_pos(h_pos), .v_line(v_line),
    .wr_stb(wr_stb), .wr_code(wr_code), .code_out(code_out), .line_out(line_out),
    .cursor_out(cursor_out), .buf_valid(buf_valid)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [5:0] m_code [1024];
  logic       m_cur  [1024];
  int         m_ptr = 0;
  logic       m_carry = 0, m_pend = 0, m_done = 0;
  logic [5:0] m_pdata = '0;
  logic [5:0] lb_code [40];
  logic       lb_cur  [40];

  logic       exp_v = 0, exp_cur = 0;
  logic [5:0] exp_code = '0;
  logic [2:0] exp_line = '0;
  int         prev_h = 0, prev_v = 0;

  int    f_err, f_valid;
  string f_msg;
  logic [5:0] cap0_code [40];
  logic [5:0] cap3_code [40];
  logic       cap0_cur  [40];
  logic       cap3_cur  [40];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(input bit tick, input int h, input int v,
                      input bit stb, input logic [5:0] code);
    logic [5:0] c;
    logic       k;
    bit         vis, sh;
    @(negedge clk);
    if (buf_valid !== exp_v ||
        (exp_v && (code_out !== exp_code || cursor_out !== exp_cur || line_out !== exp_line))) begin
      if (f_err == 0)
        f_msg = $sformatf("slot h=%0d v=%0d actual v/code/cur/line=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                          prev_h, prev_v, buf_valid, code_out, cursor_out, line_out,
                          exp_v, exp_code, exp_cur, exp_line);
      f_err++;
    end
    if (buf_valid === 1'b1) begin
      f_valid++;
      if (prev_v == 0) begin cap0_code[prev_h] = code_out; cap0_cur[prev_h] = cursor_out; end
      if (prev_v == 3) begin cap3_code[prev_h] = code_out; cap3_cur[prev_h] = cursor_out; end
    end
    char_tick = tick; h_pos = 7'(h); v_line = 8'(v); wr_stb = stb; wr_code = code;
    if (stb && !m_pend) begin m_pend = 1; m_pdata = code; end
    exp_v = 0;
    if (tick) begin
      vis = (h < 40) && (v < 192);
      sh  = (vis && (v % 8 == 0)) || (v == 192 && h < 64);
      if (sh) begin
        if (!m_done) begin c = '0; k = (m_ptr == 0); end
        else begin c = m_code[m_ptr]; k = m_cur[m_ptr]; end
        k = k | m_carry;
        m_carry = 0;
        if (m_done && m_pend && k) begin
          c = m_pdata; k = 0; m_carry = 1; m_pend = 0;
        end
        m_code[m_ptr] = c; m_cur[m_ptr] = k;
        if (m_ptr == 1023) begin m_ptr = 0; m_done = 1; end
        else m_ptr++;
        if (vis) begin lb_code[h] = c; lb_cur[h] = k; end
      end
      if (vis) begin
        exp_v = 1; exp_code = lb_code[h]; exp_cur = lb_cur[h]; exp_line = 3'(v % 8);
      end
    end
    prev_h = h; prev_v = v;
  endtask

  task automatic run_frame(input string tag, input bit gaps,
                           input int s1_line, input logic [5:0] s1_code,
                           input int s2_line, input logic [5:0] s2_code);
    f_err = 0; f_valid = 0; f_msg = "";
    for (int v = 0; v < 200; v++) begin
      if (v == s1_line) step(0, 0, v, 1, s1_code);
      if (v == s2_line) step(0, 0, v, 1, s2_code);
      for (int h = 0; h < 64; h++) begin
        if (gaps) step(0, h, v, 0, '0);
        step(1, h, v, 0, '0);
      end
    end
    step(0, 0, 0, 0, '0);
    checks++;
    if (f_err != 0) begin
      errors++;
      $display("FAIL %s frame slot mismatches=%0d first: %s", tag, f_err, f_msg);
    end
    check(f_valid == 7680, "R3", "valid pulses per frame", f_valid, 7680);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check(buf_valid == 0 && code_out == 0 && line_out == 0 && cursor_out == 0,
          "R1", "outputs in reset", {buf_valid, code_out, line_out, cursor_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(buf_valid == 0 && code_out == 0 && cursor_out == 0,
          "R1", "outputs after release", {buf_valid, code_out, cursor_out}, 0);
  endtask

  task automatic t_clear_frame;
    run_frame("R2 R3 R6 R7", 0, -1, '0, -1, '0);
    check(cap0_cur[0] == 1, "R2", "cursor at row0 col0", cap0_cur[0], 1);
    check(cap0_cur[1] == 0 && cap0_code[0] == 0, "R2", "cleared cells", {cap0_cur[1], cap0_code[0]}, 0);
  endtask

  task automatic t_pending_write;
    run_frame("R8 R7", 0, 9, 6'h11, -1, '0);
    check(cap0_code[0] == 0 && cap0_cur[0] == 1, "R8", "not stored before cursor passes",
          {cap0_cur[0], cap0_code[0]}, 64);
  endtask

  task automatic t_ignored_strobe;
    run_frame("R4 R5 R6", 0, 0, 6'h22, -1, '0);
    check(cap0_code[0] == 6'h11, "R4", "committed code at col0", cap0_code[0], 6'h11);
    check(cap0_cur[0] == 0 && cap0_cur[1] == 1, "R4", "cursor moved to col1",
          {cap0_cur[0], cap0_cur[1]}, 1);
    check(cap0_code[1] == 0, "R5", "second strobe not stored", cap0_code[1], 0);
    check(cap3_code[0] == cap0_code[0] && cap3_cur[1] == cap0_cur[1], "R6",
          "line 3 replays line 0", cap3_code[0], cap0_code[0]);
  endtask

  task automatic t_gapped_frame;
    run_frame("R3 R4 R7 R8", 1, 0, 6'h2A, 100, 6'h15);
    check(cap0_code[1] == 6'h2A && cap0_cur[2] == 1, "R4", "commit at col1, cursor col2",
          {cap0_cur[2], cap0_code[1]}, 64 + 6'h2A);
    check(cap0_code[0] == 6'h11, "R7", "col0 persists across frames", cap0_code[0], 6'h11);
  endtask

  task automatic t_late_commit;
    run_frame("R8 R7", 0, -1, '0, -1, '0);
    check(cap0_code[2] == 6'h15 && cap0_cur[3] == 1, "R8", "held code lands next frame",
          {cap0_cur[3], cap0_code[2]}, 64 + 6'h15);
  endtask

  initial begin
    t_reset_state();
    t_clear_frame();
    t_pending_write();
    t_ignored_strobe();
    t_gapped_frame();
    t_late_commit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule